// File: doc/BRIEF.md
# GPIO Input Capture and Output Steering Port

This block is a general-purpose I/O port of up to 32 pins, controlled through a small synchronous register bus on the system clock. Software writes an output-value register, an output-enable register and a per-bit auxiliary-select register, and reads back a sampled copy of the input pins. Each output pin is driven either from the output-value register or from a parallel auxiliary input bus; the auxiliary-select register chooses between them bit by bit. The output-enable bus leaving the block is active low.

The input-value register has two sampling modes. By default it follows the pins on every system clock. When the external-sampling control bit is set, it captures the pins only on one edge of an external strobe. The strobe passes through a synchronizer into the system clock domain, and an edge detector turns it into a single-cycle capture enable, so the whole block runs on one clock. A second control bit picks the falling edge instead of the rising one. Between selected edges the register holds its value, even if the pins keep changing.

The register bus is plain control: a select with a write flag, a word address, byte enables and write data. It accepts one access per cycle with no back-pressure, and it returns read data with a valid flag on the cycle after the read request. Interrupt generation and bus error responses belong to other blocks.

Top module: `gpio_steer`

## Requirements
- R1: Word addresses are 0 input value, 1 output value, 2 output enable (1 = drive), 3 auxiliary select (1 = auxiliary), 4 control. Reads of addresses 5 to 7 return zero. For a read request (`bus_sel`=1, `bus_we`=0) in one cycle, `bus_rvalid` is 1 with the data in the next cycle, and `bus_rvalid` is 0 in every other cycle.
- R2: When control bit 0 is 0, the input-value register loads the pins on every system clock. A read issued one clock after a pin change returns the new value.
- R3: When control bit 0 is 1 and control bit 1 is 0, the input-value register loads the pins only after a rising edge of `ext_strobe`, within four system clocks of that edge. The pins must stay stable over that window. A falling edge leaves the register unchanged.
- R4: In external-sampling mode, if `ext_strobe` does not toggle, the input-value register keeps its last captured value while the pins change.
- R5: When control bits 0 and 1 are both 1, the capture happens on the falling edge of `ext_strobe`, and a rising edge leaves the register unchanged.
- R6: `pin_oe_n` is the bitwise inverse of the output-enable register.
- R7: For each bit, `pin_out` equals `aux_in` where auxiliary select is 1, and the output-value register where it is 0.
- R8: Only the low N bits of each register exist. Read data bits N and above are always zero.
- R9: A write updates only the bytes whose `bus_be` bit is set (`bus_be[k]` covers data bits 8k to 8k+7).
- R10: After reset all registers are zero. The port then uses system-clock sampling, all `pin_oe_n` bits are 1, and `pin_out` follows the output-value register.
- R11: A write to address 0 has no effect. The input-value register still reflects the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address |
| bus_be | input | 4 | Byte enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| pin_in | input | N | Input pins, sampled into the input-value register |
| ext_strobe | input | 1 | External sampling strobe (asynchronous) |
| aux_in | input | N | Auxiliary output sources |
| pin_out | output | N | Output pin values |
| pin_oe_n | output | N | Active-low output enables |

## Verification
The bench builds the port with N = 12 and the default two-stage synchronizer. Because the pin count is not a multiple of eight, one byte enable covers a partial byte and the top byte enable covers nothing, and read data has twenty unused upper bits that must stay zero. The bench toggles the external strobe slowly enough to be seen through the synchronizer. It switches between rising-edge mode, falling-edge mode and system-clock mode while the register holds its last capture, so the bench can see the edges that are ignored as well as the ones that are taken.

// File: rtl/gpio_steer_pkg.sv
package gpio_steer_pkg;

  localparam int unsigned BUS_W  = 32;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned BE_W   = BUS_W / 8;

  typedef enum logic [ADDR_W-1:0] {
    REG_IN   = 3'd0,
    REG_OUT  = 3'd1,
    REG_OE   = 3'd2,
    REG_AUX  = 3'd3,
    REG_CTRL = 3'd4
  } reg_addr_e;

  // bit 0: sample on external strobe; bit 1: use falling edge
  typedef struct packed {
    logic fall_edge;
    logic ext_sample;
  } ctrl_t;

endpackage

// File: rtl/gpio_steer_regs.sv
module gpio_steer_regs
  import gpio_steer_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BE_W-1:0]   bus_be,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic [N-1:0]      in_val,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              bus_rvalid,
  output logic [N-1:0]      out_q,
  output logic [N-1:0]      oe_q,
  output logic [N-1:0]      aux_q,
  output ctrl_t             ctrl_q
);

  logic             wr_en;
  logic             rd_en;
  logic [BUS_W-1:0] rd_next;

  assign wr_en = bus_sel && bus_we;
  assign rd_en = bus_sel && !bus_we;

  // per-bit storage, each bit gated by the byte enable that covers it
  for (genvar i = 0; i < N; i++) begin : g_bit
    localparam int unsigned LANE = i / 8;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        out_q[i] <= 1'b0;
        oe_q[i]  <= 1'b0;
        aux_q[i] <= 1'b0;
      end else if (wr_en && bus_be[LANE]) begin
        if (bus_addr == REG_OUT) out_q[i] <= bus_wdata[i];
        if (bus_addr == REG_OE)  oe_q[i]  <= bus_wdata[i];
        if (bus_addr == REG_AUX) aux_q[i] <= bus_wdata[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_en && bus_be[0] && bus_addr == REG_CTRL) begin
      ctrl_q <= bus_wdata[1:0];
    end
  end

  always_comb begin
    rd_next = '0;
    case (bus_addr)
      REG_IN:   rd_next[N-1:0] = in_val;
      REG_OUT:  rd_next[N-1:0] = out_q;
      REG_OE:   rd_next[N-1:0] = oe_q;
      REG_AUX:  rd_next[N-1:0] = aux_q;
      REG_CTRL: rd_next[1:0]   = ctrl_q;
      default:  rd_next        = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd_en;
      bus_rdata  <= rd_en ? rd_next : '0;
    end
  end

endmodule

// File: rtl/gpio_steer_capture.sv
module gpio_steer_capture
  import gpio_steer_pkg::*;
#(
  parameter int unsigned N           = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ext_strobe,
  input  ctrl_t        ctrl,
  input  logic [N-1:0] pin_in,
  output logic [N-1:0] in_val
);

  // SYNC_STAGES synchronizer flops plus one history flop for edge detection
  logic [SYNC_STAGES:0] strobe_sh;
  logic                 strobe_now;
  logic                 strobe_old;
  logic                 edge_rise;
  logic                 edge_fall;
  logic                 take;

  always_ff @(posedge clk) begin
    if (!rst_n) strobe_sh <= '0;
    else        strobe_sh <= {strobe_sh[SYNC_STAGES-1:0], ext_strobe};
  end

  assign strobe_now = strobe_sh[SYNC_STAGES-1];
  assign strobe_old = strobe_sh[SYNC_STAGES];
  assign edge_rise  = strobe_now && !strobe_old;
  assign edge_fall  = !strobe_now && strobe_old;

  always_comb begin
    if (!ctrl.ext_sample)    take = 1'b1;
    else if (ctrl.fall_edge) take = edge_fall;
    else                     take = edge_rise;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    in_val <= '0;
    else if (take) in_val <= pin_in;
  end

endmodule

// File: rtl/gpio_steer_outmux.sv
module gpio_steer_outmux #(
  parameter int unsigned N = 32
) (
  input  logic [N-1:0] out_q,
  input  logic [N-1:0] oe_q,
  input  logic [N-1:0] aux_q,
  input  logic [N-1:0] aux_in,
  output logic [N-1:0] pin_out,
  output logic [N-1:0] pin_oe_n
);

  for (genvar i = 0; i < N; i++) begin : g_pin
    assign pin_out[i]  = aux_q[i] ? aux_in[i] : out_q[i];
    assign pin_oe_n[i] = !oe_q[i];
  end

endmodule

// File: rtl/gpio_steer.sv
module gpio_steer
  import gpio_steer_pkg::*;
#(
  parameter int unsigned N           = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BE_W-1:0]   bus_be,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              bus_rvalid,
  input  logic [N-1:0]      pin_in,
  input  logic              ext_strobe,
  input  logic [N-1:0]      aux_in,
  output logic [N-1:0]      pin_out,
  output logic [N-1:0]      pin_oe_n
);

  logic [N-1:0] out_q;
  logic [N-1:0] oe_q;
  logic [N-1:0] aux_q;
  logic [N-1:0] in_val;
  ctrl_t        ctrl_q;

  gpio_steer_regs #(.N(N)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_be     (bus_be),
    .bus_wdata  (bus_wdata),
    .in_val     (in_val),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .out_q      (out_q),
    .oe_q       (oe_q),
    .aux_q      (aux_q),
    .ctrl_q     (ctrl_q)
  );

  gpio_steer_capture #(.N(N), .SYNC_STAGES(SYNC_STAGES)) u_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_strobe (ext_strobe),
    .ctrl       (ctrl_q),
    .pin_in     (pin_in),
    .in_val     (in_val)
  );

  gpio_steer_outmux #(.N(N)) u_outmux (
    .out_q    (out_q),
    .oe_q     (oe_q),
    .aux_q    (aux_q),
    .aux_in   (aux_in),
    .pin_out  (pin_out),
    .pin_oe_n (pin_oe_n)
  );

endmodule

// File: rtl/gpio_steer_chk.sv
module gpio_steer_chk #(
  parameter int unsigned N = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_sel,
  input logic         bus_we,
  input logic [2:0]   bus_addr,
  input logic [3:0]   bus_be,
  input logic [31:0]  bus_wdata,
  input logic [31:0]  bus_rdata,
  input logic         bus_rvalid,
  input logic         ext_strobe,
  input logic [N-1:0] pin_oe_n,
  input logic [1:0]   ctrl,
  input logic [N-1:0] in_val
);

  // R1
  rd_gets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we) |=> bus_rvalid);

  // R1
  no_stray_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_we) |=> !bus_rvalid);

  // R6
  oe_inverse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == 3'd2 && bus_be == 4'hF)
    |=> pin_oe_n == ~$past(bus_wdata[N-1:0]));

  // R4
  hold_without_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[0] && $past(ctrl[0]) && !(bus_sel && bus_we && bus_addr == 3'd4)
     && ext_strobe == $past(ext_strobe)
     && $past(ext_strobe) == $past(ext_strobe, 2)
     && $past(ext_strobe, 2) == $past(ext_strobe, 3))
    |=> $stable(in_val));

  if (N < 32) begin : g_upper
    // R8
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rvalid |-> bus_rdata[31:N] == '0);
  end

endmodule

bind gpio_steer gpio_steer_chk #(.N(N)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_sel    (bus_sel),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_be     (bus_be),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .ext_strobe (ext_strobe),
  .pin_oe_n   (pin_oe_n),
  .ctrl       (ctrl_q),
  .in_val     (in_val)
);

// File: tb/gpio_steer_test.sv
`timescale 1ns/1ps
module gpio_steer_test;

  localparam int N = 12;
  localparam logic [31:0] MASK = (32'd1 << N) - 32'd1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0;
  logic          bus_we = 1'b0;
  logic [2:0]    bus_addr = '0;
  logic [3:0]    bus_be = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          bus_rvalid;
  logic [N-1:0]  pin_in = '0;
  logic          ext_strobe = 1'b0;
  logic [N-1:0]  aux_in = '0;
  logic [N-1:0]  pin_out;
  logic [N-1:0]  pin_oe_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  gpio_steer #(.N(N)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .pin_in(pin_in),
    .ext_strobe(ext_strobe), .aux_in(aux_in), .pin_out(pin_out),
    .pin_oe_n(pin_oe_n)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // behavioural reference model, advanced on every rising edge
  logic [31:0] m_out, m_oe, m_aux, m_in, m_ctrl, m_rdata;
  bit          m_rvalid;
  bit          ext_q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_out = 0; m_oe = 0; m_aux = 0; m_in = 0; m_ctrl = 0;
      m_rvalid = 0; m_rdata = 0;
      ext_q = '{0, 0, 0, 0};
    end else begin
      bit rose, fell, grab;
      m_rvalid = bus_sel && !bus_we;
      m_rdata = 0;
      if (m_rvalid) begin
        case (bus_addr)
          3'd0: m_rdata = m_in;
          3'd1: m_rdata = m_out;
          3'd2: m_rdata = m_oe;
          3'd3: m_rdata = m_aux;
          3'd4: m_rdata = m_ctrl;
          default: m_rdata = 0;
        endcase
      end
      ext_q.push_front(ext_strobe);
      if (ext_q.size() > 4) void'(ext_q.pop_back());
      rose = ext_q[2] && !ext_q[3];
      fell = !ext_q[2] && ext_q[3];
      grab = (m_ctrl[0] == 0) || (m_ctrl[1] ? fell : rose);
      if (grab) m_in = 32'(pin_in);
      if (bus_sel && bus_we) begin
        for (int b = 0; b < 4; b++) begin
          if (bus_be[b]) begin
            case (bus_addr)
              3'd1: m_out[8*b +: 8] = bus_wdata[8*b +: 8];
              3'd2: m_oe[8*b +: 8]  = bus_wdata[8*b +: 8];
              3'd3: m_aux[8*b +: 8] = bus_wdata[8*b +: 8];
              3'd4: if (b == 0) m_ctrl = {30'd0, bus_wdata[1:0]};
              default: ;
            endcase
          end
        end
        m_out &= MASK; m_oe &= MASK; m_aux &= MASK;
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R7 pin_out", 32'(pin_out), (32'(aux_in) & m_aux) | (m_out & ~m_aux));
      check("R6 pin_oe_n", 32'(pin_oe_n), ~m_oe & MASK);
      check("R1 rvalid", 32'(bus_rvalid), 32'(m_rvalid));
      if (m_rvalid) check("R2 rdata", bus_rdata, m_rdata);
    end
  end

  task automatic nxt(input int n = 1);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic [3:0] be);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d; bus_be = be;
    nxt();
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    nxt();
    bus_sel = 0;
    d = bus_rdata;
    check("R1 read valid", 32'(bus_rvalid), 32'd1);
  endtask

  initial begin
    logic [31:0] v;
    nxt(4);
    rst_n = 1;
    nxt();
    // R10 reset state
    check("R10 oe_n", 32'(pin_oe_n), 32'hFFF);
    check("R10 pin_out", 32'(pin_out), 32'h0);
    rd(3'd4, v); check("R10 ctrl", v, 32'h0);
    rd(3'd1, v); check("R10 out", v, 32'h0);

    // R2 system-clock sampling
    pin_in = 12'hA5C; nxt(); rd(3'd0, v); check("R2 first", v, 32'hA5C);
    pin_in = 12'h3F1; nxt(); rd(3'd0, v); check("R2 second", v, 32'h3F1);

    // R11 write to input address ignored
    wr(3'd0, 32'hFFFF_FFFF, 4'hF); rd(3'd0, v); check("R11 in", v, 32'h3F1);

    // R1 address map
    wr(3'd1, 32'h123, 4'hF); wr(3'd2, 32'h456, 4'hF); wr(3'd3, 32'h789, 4'hF);
    rd(3'd1, v); check("R1 out", v, 32'h123);
    rd(3'd2, v); check("R1 oe", v, 32'h456);
    rd(3'd3, v); check("R1 aux", v, 32'h789);
    rd(3'd5, v); check("R1 addr5", v, 32'h0);
    rd(3'd7, v); check("R1 addr7", v, 32'h0);
    nxt(); check("R1 idle", 32'(bus_rvalid), 32'h0);

    // R6 enable inversion
    wr(3'd2, 32'h0F0, 4'hF); check("R6 oe_n", 32'(pin_oe_n), 32'hF0F);

    // R9 byte enables
    wr(3'd1, 32'h0, 4'hF); wr(3'd1, 32'hFFFF_FFFF, 4'b0010);
    rd(3'd1, v); check("R9 lane1", v, 32'hF00);

    // R8 upper bits
    wr(3'd2, 32'hFFFF_FFFF, 4'hF); rd(3'd2, v); check("R8 oe", v, 32'hFFF);

    // R7 output steering
    wr(3'd1, 32'hAAA, 4'hF); aux_in = 12'hC3C; wr(3'd3, 32'h0FF, 4'hF);
    check("R7 mix1", 32'(pin_out), 32'hA3C);
    aux_in = 12'h5A5; nxt(); check("R7 mix2", 32'(pin_out), 32'hAA5);

    // R3 / R4 rising-edge capture and hold
    wr(3'd4, 32'h1, 4'hF);
    pin_in = 12'h111; nxt(4);
    rd(3'd0, v); check("R4 no edge yet", v, 32'h3F1);
    ext_strobe = 1; nxt(5);
    rd(3'd0, v); check("R3 rise captured", v, 32'h111);
    pin_in = 12'h222; nxt(6);
    rd(3'd0, v); check("R4 held", v, 32'h111);
    ext_strobe = 0; nxt(5);
    rd(3'd0, v); check("R3 fall ignored", v, 32'h111);

    // R5 falling-edge mode
    wr(3'd4, 32'h3, 4'hF);
    pin_in = 12'h333; ext_strobe = 1; nxt(5);
    rd(3'd0, v); check("R5 rise ignored", v, 32'h111);
    ext_strobe = 0; nxt(5);
    rd(3'd0, v); check("R5 fall captured", v, 32'h333);

    // back to system-clock sampling
    wr(3'd4, 32'h0, 4'hF);
    pin_in = 12'h444; nxt();
    rd(3'd0, v); check("R2 resumed", v, 32'h444);

    nxt(2);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule